// File: doc/BRIEF.md
# Memory Write Error Injector

This block sits in the write path of a single memory channel and deliberately corrupts selected write requests so that the error detection and correction logic further downstream can be exercised. Every request arrives already decoded into DIMM, rank, bank, page and column coordinates, together with a full cacheline of write data and two 32-bit groups of check bits. Requests leave in the same cycle they arrive. There is no pipeline register on this path: the only logic added is a compare and an XOR stage.

Configuration goes through a small register port. One register holds the address pattern, which has a wildcard bit for each coordinate field. A second holds a 32-bit flip mask. A third is the control word, and a write to it arms or disarms the unit. The fourth is a counter of corrupted writes.

At the moment of arming, the unit copies the pattern, the mask, the control word and the channel-population pin into working copies. While it stays armed, matching uses only those copies. A matching write then has its check bits flipped in the chosen half or halves of the cacheline, or is marked with an address parity error, or both. In one-shot mode the unit disarms after the first hit and sets a sticky completion flag. In repeat mode it keeps corrupting every matching write until software writes a control value with no inject bit set.

Top module: `wr_err_inject`

## Requirements
- R1: After synchronous reset, all four register readbacks are zero, the unit is disarmed, and write requests pass through unchanged.
- R2: The pattern register (address 0) places the column in bits 13:0, the page in bits 29:14 and the bank in bits 33:30. An armed unit fires only on a valid write for which every field that is not wildcarded equals the request's value.
- R3: The wildcard bits in the pattern register are: column bit 37, page bit 38, bank bit 39, rank bit 40, DIMM bit 41. A set wildcard bit makes its field match any value.
- R4: If the population pin was high at the time of arming, the DIMM is compared on bits 36:35 and rank bit 0 on bit 34. If the pin was low, DIMM bit 0 is compared on bit 36 and the 2-bit rank on bits 35:34.
- R5: The control word (address 2, bits 4:0) has these bits: bit 0 repeat, bits 2:1 portion, bit 3 ECC flip, bit 4 parity error. Writing it with bit 3 or bit 4 set arms a disarmed unit. Writing it with both of those bits clear disarms the unit. A hit with bit 4 set raises out_par_err in the same cycle.
- R6: On a hit with bit 3 set, the mask (address 1) is XORed into out_ecc[31:0] when the portion is 01, into out_ecc[63:32] when it is 10, and into both halves when it is 11 or 00.
- R7: In one-shot mode (bit 0 clear), the first hit corrupts that write and disarms the unit. It also sets the done flag, read at address 2 bit 5. The flag stays set until the next arm.
- R8: In repeat mode, every hit is corrupted until the control word is written with both inject bits clear.
- R9: Writes to the pattern, mask or control registers made while the unit is armed do not change the behaviour of the armed injection. They take effect at the next arm.
- R10: Whenever a write does not hit, its out_ecc equals wr_ecc and out_par_err is low. On every write, out_data equals wr_data and out_valid equals wr_valid, in the same cycle.
- R11: The counter (address 3) increments on each hit. Any write to address 3 clears it.
- R12: reg_rdata returns, one clock after reg_addr is presented, the stored pattern (address 0), the stored mask (address 1), or the stored control word with the done flag (address 2). Stored values are returned even while they are shadowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 pattern, 1 mask, 2 control, 3 counter |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Registered readback of the selected register |
| three_dimm | input | 1 | Channel holds three DIMMs; captured at arm |
| wr_valid | input | 1 | Write request valid |
| wr_dimm | input | 2 | Request DIMM |
| wr_rank | input | 2 | Request rank |
| wr_bank | input | 4 | Request bank |
| wr_page | input | 16 | Request page (row) |
| wr_col | input | 14 | Request column |
| wr_data | input | 512 | Request cacheline data |
| wr_ecc | input | 64 | Check bits, lower half in 31:0, upper half in 63:32 |
| out_valid | output | 1 | Outgoing write valid |
| out_data | output | 512 | Outgoing data, never altered |
| out_ecc | output | 64 | Outgoing check bits, possibly flipped |
| out_par_err | output | 1 | Address parity error flag for this write |

## Verification
The assertions assume that the register port and the write path do not collide on the same state in a given cycle. In particular, they assume that a counter clear does not coincide with a hit, and that a control write does not land in the cycle of a one-shot hit. The checks for counter increment and completion are therefore conditioned on no such write being present. The stimulus issues register accesses and write requests in separate cycles and never drives both at once, so every hit has a single, unambiguous effect. The random phase reprograms the pattern with random wildcard bits, random population and random control words. About half of its requests are a perturbed copy of the armed pattern, so that hits and near misses both occur often.

// File: rtl/wr_err_inject_pkg.sv
package wr_err_inject_pkg;

  // request coordinate widths
  localparam int COL_W  = 14;
  localparam int PAGE_W = 16;
  localparam int BANK_W = 4;
  localparam int RANK_W = 2;
  localparam int DIMM_W = 2;

  // pattern register layout (decoded by match logic)
  localparam int COL_LSB  = 0;
  localparam int PAGE_LSB = COL_LSB + COL_W;
  localparam int BANK_LSB = PAGE_LSB + PAGE_W;
  localparam int SEL_LSB  = BANK_LSB + BANK_W;   // 3-bit dimm/rank split
  localparam int IGN_COL  = SEL_LSB + 3;
  localparam int IGN_PAGE = IGN_COL + 1;
  localparam int IGN_BANK = IGN_COL + 2;
  localparam int IGN_RANK = IGN_COL + 3;
  localparam int IGN_DIMM = IGN_COL + 4;
  localparam int MATCH_W  = IGN_DIMM + 1;

  localparam int CTL_W = 5;

  typedef enum logic [1:0] {
    RA_PATTERN = 2'd0,
    RA_FLIPMASK = 2'd1,
    RA_CONTROL = 2'd2,
    RA_COUNTER = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic       par;      // bit 4
    logic       ecc;      // bit 3
    logic [1:0] portion;  // bits 2:1
    logic       rpt;      // bit 0
  } inj_ctl_t;

  typedef struct packed {
    logic [DIMM_W-1:0] dimm;
    logic [RANK_W-1:0] rank;
    logic [BANK_W-1:0] bank;
    logic [PAGE_W-1:0] page;
    logic [COL_W-1:0]  col;
  } req_coord_t;

endpackage

// File: rtl/wr_err_inject_regs.sv
module wr_err_inject_regs
  import wr_err_inject_pkg::*;
#(
  parameter int REG_W      = 64,
  parameter int HALF_ECC_W = 32,
  parameter int CNT_W      = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wr,
  input  logic [1:0]            reg_addr,
  input  logic [REG_W-1:0]      reg_wdata,
  output logic [REG_W-1:0]      reg_rdata,
  input  logic                  three_dimm,
  input  logic                  fire,
  output logic [MATCH_W-1:0]    act_match,
  output logic [HALF_ECC_W-1:0] act_mask,
  output inj_ctl_t              act_ctl,
  output logic                  act_three,
  output logic                  armed,
  output logic                  done,
  output logic [CNT_W-1:0]      count
);

  logic [MATCH_W-1:0]    sh_match;
  logic [HALF_ECC_W-1:0] sh_mask;
  inj_ctl_t              sh_ctl;
  inj_ctl_t              wr_ctl;
  logic                  wr_pat, wr_msk, wr_ctl_en, wr_cnt;
  logic                  arm_req;

  always_comb begin
    wr_pat    = reg_wr && (reg_addr == RA_PATTERN);
    wr_msk    = reg_wr && (reg_addr == RA_FLIPMASK);
    wr_ctl_en = reg_wr && (reg_addr == RA_CONTROL);
    wr_cnt    = reg_wr && (reg_addr == RA_COUNTER);
    wr_ctl    = inj_ctl_t'(reg_wdata[CTL_W-1:0]);
    arm_req   = wr_ctl.ecc || wr_ctl.par;
  end

  // shadow registers, always writable
  always_ff @(posedge clk) begin
    if (rst) begin
      sh_match <= '0;
      sh_mask  <= '0;
      sh_ctl   <= '0;
    end else begin
      if (wr_pat)    sh_match <= reg_wdata[MATCH_W-1:0];
      if (wr_msk)    sh_mask  <= reg_wdata[HALF_ECC_W-1:0];
      if (wr_ctl_en) sh_ctl   <= wr_ctl;
    end
  end

  // arm state and working copies
  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= 1'b0;
      done      <= 1'b0;
      act_match <= '0;
      act_mask  <= '0;
      act_ctl   <= '0;
      act_three <= 1'b0;
    end else begin
      if (fire && !act_ctl.rpt) begin
        armed <= 1'b0;
        done  <= 1'b1;
      end
      if (wr_ctl_en) begin
        if (!arm_req) begin
          armed <= 1'b0;
        end else if (!armed) begin
          armed     <= 1'b1;
          done      <= 1'b0;
          act_match <= sh_match;
          act_mask  <= sh_mask;
          act_ctl   <= wr_ctl;
          act_three <= three_dimm;
        end
      end
    end
  end

  // hit counter
  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (wr_cnt) begin
      count <= '0;
    end else if (fire) begin
      count <= count + 1'b1;
    end
  end

  // registered readback
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        RA_PATTERN:  reg_rdata <= REG_W'(sh_match);
        RA_FLIPMASK: reg_rdata <= REG_W'(sh_mask);
        RA_CONTROL:  reg_rdata <= REG_W'({done, sh_ctl});
        default:     reg_rdata <= REG_W'(count);
      endcase
    end
  end

endmodule

// File: rtl/wr_err_inject_match.sv
module wr_err_inject_match
  import wr_err_inject_pkg::*;
(
  input  logic [MATCH_W-1:0] pattern,
  input  logic               three_mode,
  input  req_coord_t         req,
  output logic               hit
);

  logic col_ok, page_ok, bank_ok, rank_ok, dimm_ok;
  logic [2:0] sel;

  always_comb begin
    sel     = pattern[SEL_LSB +: 3];
    col_ok  = pattern[IGN_COL]  || (pattern[COL_LSB +: COL_W] == req.col);
    page_ok = pattern[IGN_PAGE] || (pattern[PAGE_LSB +: PAGE_W] == req.page);
    bank_ok = pattern[IGN_BANK] || (pattern[BANK_LSB +: BANK_W] == req.bank);
    if (three_mode) begin
      dimm_ok = pattern[IGN_DIMM] || (sel[2:1] == req.dimm);
      rank_ok = pattern[IGN_RANK] || (sel[0] == req.rank[0]);
    end else begin
      dimm_ok = pattern[IGN_DIMM] || (sel[2] == req.dimm[0]);
      rank_ok = pattern[IGN_RANK] || (sel[1:0] == req.rank);
    end
    hit = col_ok && page_ok && bank_ok && rank_ok && dimm_ok;
  end

endmodule

// File: rtl/wr_err_inject_flip.sv
module wr_err_inject_flip
  import wr_err_inject_pkg::*;
#(
  parameter int HALF_ECC_W = 32,
  parameter int PORTIONS   = 2
) (
  input  logic                           fire,
  input  inj_ctl_t                       ctl,
  input  logic [HALF_ECC_W-1:0]          mask,
  input  logic [PORTIONS*HALF_ECC_W-1:0] ecc_in,
  output logic [PORTIONS*HALF_ECC_W-1:0] ecc_out,
  output logic                           par_err
);

  logic [PORTIONS-1:0] take;

  // portion code 01 selects only the lower half, 10 only the upper one
  always_comb begin
    for (int p = 0; p < PORTIONS; p++) begin
      take[p] = fire && ctl.ecc &&
                ((p == 0) ? (ctl.portion != 2'b10) : (ctl.portion != 2'b01));
    end
    par_err = fire && ctl.par;
  end

  for (genvar g = 0; g < PORTIONS; g++) begin : g_half
    assign ecc_out[g*HALF_ECC_W +: HALF_ECC_W] =
      ecc_in[g*HALF_ECC_W +: HALF_ECC_W] ^ (mask & {HALF_ECC_W{take[g]}});
  end

endmodule

// File: rtl/wr_err_inject.sv
module wr_err_inject
  import wr_err_inject_pkg::*;
#(
  parameter int DATA_W     = 512,
  parameter int HALF_ECC_W = 32,
  parameter int REG_W      = 64,
  parameter int CNT_W      = 16,
  localparam int ECC_W     = 2 * HALF_ECC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              three_dimm,
  input  logic              wr_valid,
  input  logic [1:0]        wr_dimm,
  input  logic [1:0]        wr_rank,
  input  logic [3:0]        wr_bank,
  input  logic [15:0]       wr_page,
  input  logic [13:0]       wr_col,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ECC_W-1:0]  wr_ecc,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [ECC_W-1:0]  out_ecc,
  output logic              out_par_err
);

  logic [MATCH_W-1:0]    act_match;
  logic [HALF_ECC_W-1:0] act_mask;
  inj_ctl_t              act_ctl;
  logic                  act_three;
  logic                  armed;
  logic                  done;
  logic [CNT_W-1:0]      count;
  logic                  hit;
  logic                  fire;
  req_coord_t            req;

  assign req = '{dimm: wr_dimm, rank: wr_rank, bank: wr_bank,
                 page: wr_page, col: wr_col};

  wr_err_inject_regs #(
    .REG_W(REG_W), .HALF_ECC_W(HALF_ECC_W), .CNT_W(CNT_W)
  ) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .three_dimm(three_dimm),
    .fire(fire), .act_match(act_match), .act_mask(act_mask),
    .act_ctl(act_ctl), .act_three(act_three), .armed(armed), .done(done),
    .count(count)
  );

  wr_err_inject_match u_match (
    .pattern(act_match), .three_mode(act_three), .req(req), .hit(hit)
  );

  assign fire = armed && wr_valid && hit;

  wr_err_inject_flip #(
    .HALF_ECC_W(HALF_ECC_W), .PORTIONS(2)
  ) u_flip (
    .fire(fire), .ctl(act_ctl), .mask(act_mask), .ecc_in(wr_ecc),
    .ecc_out(out_ecc), .par_err(out_par_err)
  );

  assign out_valid = wr_valid;
  assign out_data  = wr_data;

endmodule

// File: rtl/wr_err_inject_chk.sv
module wr_err_inject_chk #(
  parameter int DATA_W     = 512,
  parameter int HALF_ECC_W = 32,
  parameter int CNT_W      = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    reg_wr,
  input logic [1:0]              reg_addr,
  input logic                    armed,
  input logic                    fire,
  input logic                    rpt,
  input logic                    done,
  input logic [CNT_W-1:0]        count,
  input logic [DATA_W-1:0]       wr_data,
  input logic [DATA_W-1:0]       out_data,
  input logic [2*HALF_ECC_W-1:0] wr_ecc,
  input logic [2*HALF_ECC_W-1:0] out_ecc,
  input logic                    out_par_err
);

  logic ctl_wr, cnt_wr;
  assign ctl_wr = reg_wr && (reg_addr == 2'd2);
  assign cnt_wr = reg_wr && (reg_addr == 2'd3);

  // R10
  disarmed_pass_chk: assert property (@(posedge clk) disable iff (rst)
    !armed |-> (out_ecc == wr_ecc && !out_par_err));

  // R10
  data_pass_chk: assert property (@(posedge clk) disable iff (rst)
    out_data == wr_data);

  // R5
  par_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
    out_par_err |-> armed);

  // R7
  oneshot_disarm_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && !rpt && !ctl_wr) |=> (!armed && done));

  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !ctl_wr) |=> done);

  // R8
  repeat_stays_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && rpt && !ctl_wr) |=> armed);

  // R11
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && !cnt_wr) |=> (count == CNT_W'($past(count) + 1'b1)));

  // R11
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!fire && !cnt_wr) |=> $stable(count));

endmodule

bind wr_err_inject wr_err_inject_chk #(
  .DATA_W(DATA_W), .HALF_ECC_W(HALF_ECC_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .armed(armed), .fire(fire), .rpt(act_ctl.rpt), .done(done),
  .count(count), .wr_data(wr_data), .out_data(out_data),
  .wr_ecc(wr_ecc), .out_ecc(out_ecc), .out_par_err(out_par_err)
);

// File: tb/wr_err_inject_tb.sv
module wr_err_inject_tb;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         reg_wr = 1'b0;
  logic [1:0]   reg_addr = '0;
  logic [63:0]  reg_wdata = '0;
  logic [63:0]  reg_rdata;
  logic         three_dimm = 1'b0;
  logic         wr_valid = 1'b0;
  logic [1:0]   wr_dimm = '0;
  logic [1:0]   wr_rank = '0;
  logic [3:0]   wr_bank = '0;
  logic [15:0]  wr_page = '0;
  logic [13:0]  wr_col = '0;
  logic [511:0] wr_data = '0;
  logic [63:0]  wr_ecc = '0;
  logic         out_valid;
  logic [511:0] out_data;
  logic [63:0]  out_ecc;
  logic         out_par_err;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  wr_err_inject u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .three_dimm(three_dimm),
    .wr_valid(wr_valid), .wr_dimm(wr_dimm), .wr_rank(wr_rank),
    .wr_bank(wr_bank), .wr_page(wr_page), .wr_col(wr_col),
    .wr_data(wr_data), .wr_ecc(wr_ecc), .out_valid(out_valid),
    .out_data(out_data), .out_ecc(out_ecc), .out_par_err(out_par_err)
  );

  // bench model of the register state
  logic [41:0] m_sh_match, m_act_match;
  logic [31:0] m_sh_mask, m_act_mask;
  logic [4:0]  m_sh_ctl, m_act_ctl;
  logic        m_act_three, m_armed, m_done;
  logic [15:0] m_cnt;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic model_hit(logic [1:0] d, logic [1:0] r,
      logic [3:0] b, logic [15:0] p, logic [13:0] c);
    logic ok;
    ok = (m_act_match[37] || m_act_match[13:0] == c) &&
         (m_act_match[38] || m_act_match[29:14] == p) &&
         (m_act_match[39] || m_act_match[33:30] == b);
    if (m_act_three)
      ok = ok && (m_act_match[41] || m_act_match[36:35] == d) &&
                 (m_act_match[40] || m_act_match[34] == r[0]);
    else
      ok = ok && (m_act_match[41] || m_act_match[36] == d[0]) &&
                 (m_act_match[40] || m_act_match[35:34] == r);
    return ok;
  endfunction

  function automatic logic [63:0] model_ecc(logic f, logic [63:0] e);
    logic [63:0] r;
    r = e;
    if (f && m_act_ctl[3]) begin
      if (m_act_ctl[2:1] != 2'b10) r[31:0]  = r[31:0] ^ m_act_mask;
      if (m_act_ctl[2:1] != 2'b01) r[63:32] = r[63:32] ^ m_act_mask;
    end
    return r;
  endfunction

  task automatic model_reset();
    m_sh_match = '0; m_act_match = '0; m_sh_mask = '0; m_act_mask = '0;
    m_sh_ctl = '0; m_act_ctl = '0; m_act_three = 0; m_armed = 0;
    m_done = 0; m_cnt = '0;
  endtask

  // entered just after a falling edge
  task automatic reg_write(logic [1:0] a, logic [63:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    case (a)
      2'd0: m_sh_match = d[41:0];
      2'd1: m_sh_mask = d[31:0];
      2'd2: begin
        m_sh_ctl = d[4:0];
        if (d[4:3] == 2'b00) m_armed = 0;
        else if (!m_armed) begin
          m_armed = 1; m_done = 0; m_act_match = m_sh_match;
          m_act_mask = m_sh_mask; m_act_ctl = d[4:0]; m_act_three = three_dimm;
        end
      end
      default: m_cnt = '0;
    endcase
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_check(string tag, logic [1:0] a);
    logic [63:0] exp;
    reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    case (a)
      2'd0: exp = 64'(m_sh_match);
      2'd1: exp = 64'(m_sh_mask);
      2'd2: exp = 64'({m_done, m_sh_ctl});
      default: exp = 64'(m_cnt);
    endcase
    chk(tag, reg_rdata, exp);
  endtask

  task automatic send(string tag, logic [1:0] d, logic [1:0] r,
      logic [3:0] b, logic [15:0] p, logic [13:0] c);
    logic f;
    wr_valid = 1'b1; wr_dimm = d; wr_rank = r; wr_bank = b;
    wr_page = p; wr_col = c;
    for (int i = 0; i < 16; i++) wr_data[i*32 +: 32] = $urandom;
    wr_ecc = {$urandom, $urandom};
    #1;
    f = m_armed && model_hit(d, r, b, p, c);
    chk({tag, " ecc"}, out_ecc, model_ecc(f, wr_ecc));
    chk({tag, " par"}, 64'(out_par_err), 64'(f && m_act_ctl[4]));
    chk("R10 data", 64'(out_data == wr_data), 64'd1);
    chk("R10 valid", 64'(out_valid), 64'd1);
    @(posedge clk);
    if (f) begin
      m_cnt = m_cnt + 1'b1;
      if (!m_act_ctl[0]) begin m_armed = 0; m_done = 1; end
    end
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // pattern builder
  function automatic logic [63:0] pat(logic [4:0] ign, logic [2:0] sel,
      logic [3:0] b, logic [15:0] p, logic [13:0] c);
    return 64'({ign, sel, b, p, c});
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [63:0] tp;
    logic [1:0] rd, rr; logic [3:0] rb; logic [15:0] rp; logic [13:0] rc;
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int a = 0; a < 4; a++) reg_check("R1 reset readback", 2'(a));
    send("R1 disarmed", 2'd1, 2'd1, 4'd3, 16'h1234, 14'h0aa);

    // R2 R6 one-shot lower half, exact pattern (two-DIMM mode: dimm0=1, rank=2)
    tp = pat(5'b0, 3'b110, 4'd5, 16'hbeef, 14'h123);
    reg_write(2'd0, tp);
    reg_write(2'd1, 64'h0000_00ff);
    reg_write(2'd2, 64'h0a);
    send("R2 col miss", 2'd1, 2'd2, 4'd5, 16'hbeef, 14'h124);
    send("R2 bank miss", 2'd1, 2'd2, 4'd6, 16'hbeef, 14'h123);
    send("R6 lower hit", 2'd1, 2'd2, 4'd5, 16'hbeef, 14'h123);
    send("R7 after oneshot", 2'd1, 2'd2, 4'd5, 16'hbeef, 14'h123);
    reg_check("R7 done flag", 2'd2);
    reg_check("R11 count one", 2'd3);

    // R6 other portions
    reg_write(2'd2, 64'h0c);
    send("R6 upper hit", 2'd1, 2'd2, 4'd5, 16'hbeef, 14'h123);
    reg_write(2'd2, 64'h0e);
    send("R6 full hit", 2'd1, 2'd2, 4'd5, 16'hbeef, 14'h123);
    reg_write(2'd2, 64'h08);
    send("R6 nomask hit", 2'd1, 2'd2, 4'd5, 16'hbeef, 14'h123);

    // R8 repeat, R9 shadowing while armed
    reg_write(2'd2, 64'h0b);
    reg_check("R7 done cleared on arm", 2'd2);
    send("R8 repeat 1", 2'd1, 2'd2, 4'd5, 16'hbeef, 14'h123);
    reg_write(2'd0, pat(5'b0, 3'b000, 4'd1, 16'h1, 14'h1));
    reg_write(2'd1, 64'hffff_0000);
    reg_write(2'd2, 64'h1e);
    send("R9 old pattern", 2'd1, 2'd2, 4'd5, 16'hbeef, 14'h123);
    send("R9 new pattern ignored", 2'd0, 2'd0, 4'd1, 16'h1, 14'h1);
    reg_check("R12 shadow pattern", 2'd0);
    reg_check("R12 shadow mask", 2'd1);
    send("R8 repeat 3", 2'd1, 2'd2, 4'd5, 16'hbeef, 14'h123);
    reg_write(2'd2, 64'h00);
    send("R8 cleared", 2'd1, 2'd2, 4'd5, 16'hbeef, 14'h123);

    // R5 parity only, R9 new values now live
    reg_write(2'd2, 64'h10);
    send("R5 parity hit", 2'd0, 2'd0, 4'd1, 16'h1, 14'h1);

    // R3 all wildcards
    reg_write(2'd0, pat(5'b11111, 3'b0, 4'd0, 16'h0, 14'h0));
    reg_write(2'd2, 64'h1f);
    send("R3 any 1", 2'd3, 2'd1, 4'd9, 16'h7777, 14'h3fff);
    send("R3 any 2", 2'd0, 2'd3, 4'd2, 16'h0001, 14'h0001);
    reg_write(2'd2, 64'h00);

    // R4 dimm/rank split, pattern bits 36:34 = 101
    reg_write(2'd0, pat(5'b0, 3'b101, 4'd0, 16'h0, 14'h0));
    three_dimm = 1'b1;
    reg_write(2'd2, 64'h0f);
    send("R4 three hit", 2'd2, 2'd3, 4'd0, 16'h0, 14'h0);
    send("R4 three miss", 2'd1, 2'd1, 4'd0, 16'h0, 14'h0);
    reg_write(2'd2, 64'h00);
    three_dimm = 1'b0;
    reg_write(2'd2, 64'h0f);
    three_dimm = 1'b1;   // captured at arm only
    send("R4 two hit", 2'd1, 2'd1, 4'd0, 16'h0, 14'h0);
    send("R4 two miss", 2'd2, 2'd3, 4'd0, 16'h0, 14'h0);
    reg_write(2'd2, 64'h00);

    // R11 counter clear
    reg_check("R11 count before clear", 2'd3);
    reg_write(2'd3, 64'h0);
    reg_check("R11 count cleared", 2'd3);

    // random phase
    for (int it = 0; it < 400; it++) begin
      if (it % 16 == 0) begin
        reg_write(2'd2, 64'h00);
        tp = pat(5'($urandom & ($urandom & 5'h1f)), 3'($urandom),
                 4'($urandom), 16'($urandom), 14'($urandom));
        reg_write(2'd0, tp);
        reg_write(2'd1, 64'($urandom));
        three_dimm = 1'($urandom);
        reg_write(2'd2, 64'($urandom % 31 + 1) | 64'h08);
      end
      if ($urandom % 2 == 0) begin
        rc = tp[13:0]; rp = tp[29:14]; rb = tp[33:30];
        if (m_act_three) begin rd = tp[36:35]; rr = {1'($urandom), tp[34]}; end
        else begin rd = {1'($urandom), tp[36]}; rr = tp[35:34]; end
        case ($urandom % 6)
          0: rc = rc ^ 14'h1;
          1: rb = rb ^ 4'h2;
          2: rd = rd ^ 2'h1;
          default: ;
        endcase
      end else begin
        rd = 2'($urandom); rr = 2'($urandom); rb = 4'($urandom);
        rp = 16'($urandom); rc = 14'($urandom);
      end
      send("R2 R10 random", rd, rr, rb, rp, rc);
      if (it % 50 == 49) reg_check("R11 random count", 2'd3);
    end
    reg_check("R7 random ctl", 2'd2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule